// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned operands of a parameterized width one bit position per clock, least significant bit first. Each operand sits in its own right-shifting register. The result builds up in a third shift register that fills from its most significant end. A one-bit carry machine turns each operand bit pair into a sum bit and a new carry. After the last bit, the final carry is presented as the extra high-order result bit.

A compile-time switch selects one of two carry machines. The first has two states, one for each carry value, and produces the sum bit combinationally from the state and the current operand bits. The second has four states, each pairing a carry value with the sum bit to be output. Its sum bit therefore comes from a register, and the result stream lags the two-state machine by exactly one clock. That variant runs one extra cycle so that the last sum bit lands in the result register.

In use, the operands are loaded in parallel while the block is idle and a start pulse is given. The caller then waits for the done flag and reads the parallel sum and the carry-out bit. Both stay valid until the next start.

Top module: `ser_add`

## Requirements
- R1: After reset, busy, done, sum and carry_out are all 0.
- R2: A load pulse while busy is 0 captures op_a and op_b as the operands of the next addition.
- R3: A start pulse while busy is 0 sets busy and clears done in the following cycle.
- R4: With MOORE=0, done rises exactly W cycles after the start edge. sum then equals (A+B) mod 2^W and carry_out equals bit W of A+B.
- R5: With MOORE=1, done rises exactly W+1 cycles after the start edge, with the same sum and carry_out values as in R4.
- R6: A start pulse while busy is 1 is ignored, including one on the last busy cycle: latency and result are unchanged.
- R7: A load pulse while busy is 1 is ignored: the running addition still yields A+B of the originally loaded operands.
- R8: While done is 1 and no start arrives, done stays 1 and sum and carry_out stay constant, even if new operands are loaded.
- R9: Every addition begins with the carry cleared, so a run that ended with carry_out=1 does not leak into the next one.
- R10: A load and a start given in the same idle cycle start an addition of the newly loaded operands.
- R11: Sum bits enter sum at bit W-1, LSB first. With MOORE=0, after busy cycle j (1..W) sum[W-1] equals bit j-1 of A+B. With MOORE=1, after busy cycle j (2..W+1) it equals bit j-2, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Parallel load of both operands, honoured only when idle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| start | input | 1 | Begins an addition, honoured only when idle |
| busy | output | 1 | Addition in progress |
| done | output | 1 | Result valid; held until the next accepted start |
| sum | output | W | Result register (low W bits of A+B once done) |
| carry_out | output | 1 | Final carry, bit W of A+B once done |

## Verification
Two pairs of functions can coincide: a load with a start in the same idle cycle, and a stray start with the final busy cycle, when the controller is about to raise done. The bench drives load and start together and expects the sum of the new operands (R10). It also fires start on the cycle just before completion, when a careless controller would restart. It judges the outcome by the exact done latency, which differs by one clock between the two carry machines, and by the final sum and carry. Both variants run side by side on identical stimulus, so the one-clock stream lag is checked bit by bit as well.

// File: rtl/ser_add_pkg.sv
`timescale 1ns/1ps
package ser_add_pkg;

    typedef enum logic {
        CY_G = 1'b0,
        CY_H = 1'b1
    } mealy_st_t;

    // bit 1 = carry, bit 0 = sum bit presented
    typedef enum logic [1:0] {
        MO_G0 = 2'b00,
        MO_G1 = 2'b01,
        MO_H0 = 2'b10,
        MO_H1 = 2'b11
    } moore_st_t;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/ser_add_ctrl.sv
`timescale 1ns/1ps
module ser_add_ctrl #(
    parameter int unsigned N     = 8,
    parameter bit          MOORE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic step_en,
    output logic clr
);
    localparam int unsigned LAST = N - 1 + (MOORE ? 1 : 0);
    localparam int unsigned CW   = $clog2(LAST + 2);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        clr = 1'b0;
        if (!r_q.busy) begin
            if (start) begin
                r_d.busy = 1'b1;
                r_d.done = 1'b0;
                r_d.cnt  = '0;
                clr      = 1'b1;
            end
        end else if (r_q.cnt == CW'(LAST)) begin
            r_d.busy = 1'b0;
            r_d.done = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy    = r_q.busy;
    assign done    = r_q.done;
    assign step_en = r_q.busy && (r_q.cnt < CW'(N));

endmodule

// File: rtl/ser_add_carry.sv
`timescale 1ns/1ps
module ser_add_carry
    import ser_add_pkg::*;
#(
    parameter bit MOORE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic a,
    input  logic b,
    output logic sum_bit,
    output logic carry
);
    generate
        if (MOORE) begin : g_moore
            moore_st_t   st_q, st_d;
            logic [1:0]  st_bits;
            logic        c_now;

            assign st_bits = st_q;
            assign c_now   = st_bits[1];

            always_comb begin
                st_d = st_q;
                if (clr)     st_d = MO_G0;
                else if (en) st_d = moore_st_t'({maj3(a, b, c_now), a ^ b ^ c_now});
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= MO_G0;
                else        st_q <= st_d;
            end

            assign sum_bit = st_bits[0];
            assign carry   = c_now;
        end else begin : g_mealy
            mealy_st_t cy_q, cy_d;
            logic      c_now;

            assign c_now = (cy_q == CY_H);

            always_comb begin
                cy_d = cy_q;
                if (clr) begin
                    cy_d = CY_G;
                end else if (en) begin
                    case (cy_q)
                        CY_G:    if (a & b)   cy_d = CY_H;
                        CY_H:    if (!a & !b) cy_d = CY_G;
                        default: cy_d = CY_G;
                    endcase
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cy_q <= CY_G;
                else        cy_q <= cy_d;
            end

            assign sum_bit = a ^ b ^ c_now;
            assign carry   = c_now;
        end
    endgenerate

endmodule

// File: rtl/ser_add.sv
`timescale 1ns/1ps
module ser_add #(
    parameter int unsigned W     = 8,
    parameter bit          MOORE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         start,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] sum;
    } dp_t;

    dp_t  dp_q, dp_d;
    logic step_en, clr, sbit, cy;
    logic [W:0] sum_ext;

    ser_add_ctrl #(.N(W), .MOORE(MOORE)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .step_en (step_en),
        .clr     (clr)
    );

    ser_add_carry #(.MOORE(MOORE)) u_carry (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (step_en),
        .a       (dp_q.a[0]),
        .b       (dp_q.b[0]),
        .sum_bit (sbit),
        .carry   (cy)
    );

    assign sum_ext = {sbit, dp_q.sum};

    always_comb begin
        dp_d = dp_q;
        if (load && !busy) begin
            dp_d.a = op_a;
            dp_d.b = op_b;
        end else if (step_en) begin
            dp_d.a = dp_q.a >> 1;
            dp_d.b = dp_q.b >> 1;
        end
        if (busy) dp_d.sum = sum_ext[W:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign sum       = dp_q.sum;
    assign carry_out = cy;

endmodule

// File: rtl/ser_add_chk.sv
`timescale 1ns/1ps
module ser_add_chk #(
    parameter int unsigned W     = 8,
    parameter bit          MOORE = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] sum,
    input logic         carry_out
);
    localparam int unsigned LAT = W + (MOORE ? 1 : 0);

    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    a_r6_busy_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    a_r4_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == LAT));

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(sum) && $stable(carry_out)));

endmodule

bind ser_add ser_add_chk #(.W(W), .MOORE(MOORE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/ser_add_test.sv
`timescale 1ns/1ps
module ser_add_test;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n, load, start;
    logic [W-1:0] op_a, op_b;
    logic         busy_e, done_e, cy_e, busy_o, done_o, cy_o;
    logic [W-1:0] sum_e, sum_o;

    int checks = 0;
    int fails  = 0;

    ser_add #(.W(W), .MOORE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .load(load), .op_a(op_a), .op_b(op_b),
        .start(start), .busy(busy_e), .done(done_e), .sum(sum_e), .carry_out(cy_e)
    );

    ser_add #(.W(W), .MOORE(1'b1)) uut_moore (
        .clk(clk), .rst_n(rst_n), .load(load), .op_a(op_a), .op_b(op_b),
        .start(start), .busy(busy_o), .done(done_o), .sum(sum_o), .carry_out(cy_o)
    );

    function automatic logic [W:0] exp_add(input logic [W-1:0] x, input logic [W-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add_run(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit together, input int inj, input bit inj_load,
                           input string req);
        logic [W:0] e;
        int n, dl_e, dl_o;
        e = exp_add(a, b);
        @(negedge clk);
        load = 1'b1; op_a = a; op_b = b; start = together;
        if (!together) begin
            @(negedge clk);
            load = 1'b0; start = 1'b1;
        end
        @(negedge clk);
        load = 1'b0; start = 1'b0;
        chk("R3", "busy after start (two-state)", 32'(busy_e), 32'd1);
        chk("R3", "done after start (two-state)", 32'(done_e), 32'd0);
        chk("R3", "busy after start (four-state)", 32'(busy_o), 32'd1);
        n = 0; dl_e = -1; dl_o = -1;
        while ((dl_e < 0 || dl_o < 0) && n < 4 * W + 8) begin
            start = (inj > 0) && (n == inj);
            load  = start && inj_load;
            if (load) begin
                op_a = ~a; op_b = ~b;
            end
            @(negedge clk);
            n++;
            start = 1'b0; load = 1'b0;
            if (n >= 1 && n <= W)
                chk("R11", "stream bit (two-state)", 32'(sum_e[W-1]), 32'(e[n-1]));
            if (n >= 2 && n <= W + 1)
                chk("R11", "stream bit (four-state)", 32'(sum_o[W-1]), 32'(e[n-2]));
            if (done_e && dl_e < 0) dl_e = n;
            if (done_o && dl_o < 0) dl_o = n;
        end
        chk({req, "/R4"}, "latency (two-state)", 32'(dl_e), 32'(W));
        chk({req, "/R4"}, "sum (two-state)", 32'(sum_e), 32'(e[W-1:0]));
        chk({req, "/R4"}, "carry_out (two-state)", 32'(cy_e), 32'(e[W]));
        chk({req, "/R5"}, "latency (four-state)", 32'(dl_o), 32'(W + 1));
        chk({req, "/R5"}, "sum (four-state)", 32'(sum_o), 32'(e[W-1:0]));
        chk({req, "/R5"}, "carry_out (four-state)", 32'(cy_o), 32'(e[W]));
        // R8: idle load must not disturb a held result
        load = 1'b1; op_a = a ^ 8'h5A; op_b = b ^ 8'hC3;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        chk("R8", "done held", 32'({done_e, done_o}), 32'd3);
        chk("R8", "sum held (two-state)", 32'({cy_e, sum_e}), 32'(e));
        chk("R8", "sum held (four-state)", 32'({cy_o, sum_o}), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; load = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "outputs in reset (two-state)", 32'({busy_e, done_e, cy_e, sum_e}), 32'd0);
        chk("R1", "outputs in reset (four-state)", 32'({busy_o, done_o, cy_o, sum_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset release", 32'({busy_e, done_e, busy_o, done_o}), 32'd0);

        add_run(8'd23, 8'd42, 1'b0, 0, 1'b0, "R2");
        add_run(8'hFF, 8'h01, 1'b0, 0, 1'b0, "R4");
        add_run(8'h00, 8'h00, 1'b0, 0, 1'b0, "R9");
        add_run(8'hFF, 8'hFF, 1'b1, 0, 1'b0, "R10");
        add_run(8'hAA, 8'h55, 1'b0, 3, 1'b0, "R6");
        add_run(8'h81, 8'h7F, 1'b0, W - 1, 1'b0, "R6");
        add_run(8'h3C, 8'hC4, 1'b0, 2, 1'b1, "R7");
        add_run(8'h80, 8'h80, 1'b1, 0, 1'b0, "R5");

        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] ra, rb;
            int ri;
            ra = W'($urandom);
            rb = W'($urandom);
            ri = ($urandom % 4 == 0) ? int'(1 + $urandom % (W - 1)) : 0;
            add_run(ra, rb, 1'($urandom), ri, 1'($urandom), "R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule